// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits behind the byte-load controller of a sector-programmed flash array. Every load event, an address and a data byte, passes through it. The decoder looks for the multi-write unlock sequences written to fixed command addresses. Loads that form part of a sequence are absorbed. All other loads are forwarded with a verdict that says whether the array may store them.

The decoder holds five pieces of state:
- whether software write protection is enabled
- whether identification mode is active
- a programming lock for the bottom boot block
- a programming lock for the top boot block
- whether a one-shot write window is open

The write window opens after the three-write program unlock. It closes when the write controller reports that the program cycle has ended.

A six-write prefix leads to one of three commands: protection disable, boot-block lock or chip erase. Chip erase is issued as a single-cycle request and is refused while either boot block is locked. In identification mode the decoder supplies read data for the identification locations on a combinational read port.

Top module: `cmd_seq_decoder`

## Requirements
- R1: After reset, protection, identification mode and both locks are clear, no window is open, `wr_permit_o` is 1, and `ld_pass_o`, `ld_store_o` and `erase_req_o` are 0.
- R2: Command addresses are compared on address bits [14:0] only. Bits above 14 are ignored, so AA at 0x15555 counts as AA at 0x5555.
- R3: The sequence AA@5555, 55@2AAA, A0@5555 does three things. It sets protection, it opens a write window in which every load is passed, and it keeps `wr_permit_o` at 1 until `prog_done_i` is seen. After `prog_done_i`, `wr_permit_o` follows the protection flag, which stays set.
- R4: With protection set and no window open, an ordinary load gives `ld_pass_o`=1 and `ld_store_o`=0. The write timer starts, but no data is stored.
- R5: The six writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 clear protection.
- R6: Two sequences set and clear identification mode. AA@5555, 55@2AAA, 90@5555 enters the mode. The same prefix ending in F0@5555 leaves it.
  - In the mode, the read port returns 1F at address 0 and D5 at address 1.
  - Every other identification read, and every read outside the mode, returns 00.
- R7: The six-write prefix ending in 40@5555 arms the boot-block lock. The next load then picks which block to lock.
  - 00 written to address 0 locks the bottom block.
  - FF written to the all-ones address locks the top block.
  - Locks never clear.
  - In identification mode, address 0x00002 reads the bottom lock status and address 0x1FFF2 reads the top lock status. The value is FE when the block is unlocked and FF when it is locked.
- R8: A passed load whose address lies in a locked 8 KB boot block has `ld_store_o`=0, even when protection is off. Address bits [16:13] all 0 mark the bottom block, and all 1 mark the top block.
- R9: The six-write prefix ending in 10@5555 pulses `erase_req_o` for one cycle, but only if neither boot block is locked.
- R10: A load that does not match the next expected step returns the decoder to idle and is passed as an ordinary load. A fresh sequence may start on the next load.
- R11: `ld_pass_o`, `ld_store_o` and `erase_req_o` are single-cycle pulses. They rise in the cycle after the load is sampled, and never without a load. Command writes give `ld_pass_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_valid_i | input | 1 | One load event this cycle |
| ld_addr_i | input | 17 | Load address |
| ld_data_i | input | 8 | Load data |
| prog_done_i | input | 1 | Program cycle finished (closes window) |
| rd_addr_i | input | 17 | Read address for identification data |
| ld_pass_o | output | 1 | Previous load is an ordinary load (timer starts) |
| ld_store_o | output | 1 | Previous load may be stored in the array |
| erase_req_o | output | 1 | Chip erase request pulse |
| wr_permit_o | output | 1 | Ordinary loads would be stored now |
| sw_prot_o | output | 1 | Software protection enabled |
| id_mode_o | output | 1 | Identification mode active |
| lock_lo_o | output | 1 | Bottom boot block locked |
| lock_hi_o | output | 1 | Top boot block locked |
| id_rd_data_o | output | 8 | Identification read data |

## Verification
The verdict and erase pulses for a load are due exactly one clock after the edge that samples the load. The mode and lock flags change on that same edge. Identification read data is combinational on the registered flags, so it is valid in the same cycle as a new read address.

The driver raises `ld_valid_i` at a falling edge and pushes the expected verdict into a queue. The monitor pops and compares at the next falling edge, when the registered outputs have settled. At every other falling edge it flags any stray pulse.

Flag and read-port checks are made only after the driver task has returned. At that point the edge that updated the flags has already passed.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_AA1, ST_551, ST_80, ST_AA2, ST_552, ST_LOCK, ST_WIN
  } seq_st_e;

  typedef struct packed {
    logic at_5555;
    logic at_2aaa;
    logic at_base;
    logic at_top;
    logic in_lo_blk;
    logic in_hi_blk;
  } addr_hit_t;

  localparam logic [7:0] D_AA   = 8'hAA;
  localparam logic [7:0] D_55   = 8'h55;
  localparam logic [7:0] D_PGM  = 8'hA0;
  localparam logic [7:0] D_IDIN = 8'h90;
  localparam logic [7:0] D_IDEX = 8'hF0;
  localparam logic [7:0] D_EXT  = 8'h80;
  localparam logic [7:0] D_UNPR = 8'h20;
  localparam logic [7:0] D_LOCK = 8'h40;
  localparam logic [7:0] D_ERAS = 8'h10;
  localparam logic [7:0] D_LLO  = 8'h00;
  localparam logic [7:0] D_LHI  = 8'hFF;
endpackage

// File: rtl/cmd_addr_match.sv
module cmd_addr_match
  import cmd_seq_pkg::*;
#(
  parameter int AW    = 17,
  parameter int CMP_W = 15,
  parameter int BLK_W = 13
) (
  input  logic [AW-1:0] addr_i,
  output addr_hit_t     hit_o
);
  localparam int HI_W = AW - BLK_W;
  localparam logic [CMP_W-1:0] A_5555 = CMP_W'(15'h5555);
  localparam logic [CMP_W-1:0] A_2AAA = CMP_W'(15'h2AAA);

  always_comb begin
    hit_o.at_5555   = addr_i[CMP_W-1:0] == A_5555;
    hit_o.at_2aaa   = addr_i[CMP_W-1:0] == A_2AAA;
    hit_o.at_base   = addr_i == '0;
    hit_o.at_top    = &addr_i;
    hit_o.in_lo_blk = addr_i[AW-1:BLK_W] == {HI_W{1'b0}};
    hit_o.in_hi_blk = &addr_i[AW-1:BLK_W];
  end
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import cmd_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ld_valid_i,
  input  logic [7:0] ld_data_i,
  input  addr_hit_t hit_i,
  input  logic      prog_done_i,
  output logic      ld_pass_o,
  output logic      ld_store_o,
  output logic      erase_req_o,
  output logic      wr_permit_o,
  output logic      sw_prot_o,
  output logic      id_mode_o,
  output logic      lock_lo_o,
  output logic      lock_hi_o
);
  seq_st_e st_q, st_d;
  logic prot_q, prot_d, id_q, id_d, llo_q, llo_d, lhi_q, lhi_d;
  logic absorb, erase_d, pass_d, store_d, permit, blk_locked;
  logic pass_q, store_q, erase_q;

  assign permit     = !prot_q || (st_q == ST_WIN);
  assign blk_locked = (hit_i.in_lo_blk && llo_q) || (hit_i.in_hi_blk && lhi_q);

  always_comb begin
    st_d = st_q; prot_d = prot_q; id_d = id_q; llo_d = llo_q; lhi_d = lhi_q;
    absorb = 1'b0; erase_d = 1'b0;
    if (ld_valid_i) begin
      unique case (st_q)
        ST_IDLE: if (hit_i.at_5555 && ld_data_i == D_AA) begin st_d = ST_AA1; absorb = 1'b1; end
        ST_AA1:  if (hit_i.at_2aaa && ld_data_i == D_55) begin st_d = ST_551; absorb = 1'b1; end
        ST_551: if (hit_i.at_5555) begin
          absorb = 1'b1;
          unique case (ld_data_i)
            D_PGM:   begin prot_d = 1'b1; st_d = ST_WIN; end
            D_IDIN:  begin id_d = 1'b1; st_d = ST_IDLE; end
            D_IDEX:  begin id_d = 1'b0; st_d = ST_IDLE; end
            D_EXT:   st_d = ST_80;
            default: absorb = 1'b0;
          endcase
        end
        ST_80:   if (hit_i.at_5555 && ld_data_i == D_AA) begin st_d = ST_AA2; absorb = 1'b1; end
        ST_AA2:  if (hit_i.at_2aaa && ld_data_i == D_55) begin st_d = ST_552; absorb = 1'b1; end
        ST_552: if (hit_i.at_5555) begin
          absorb = 1'b1;
          unique case (ld_data_i)
            D_UNPR:  begin prot_d = 1'b0; st_d = ST_IDLE; end
            D_LOCK:  st_d = ST_LOCK;
            D_ERAS:  begin erase_d = !(llo_q || lhi_q); st_d = ST_IDLE; end
            default: absorb = 1'b0;
          endcase
        end
        ST_LOCK: begin
          if (hit_i.at_base && ld_data_i == D_LLO) begin llo_d = 1'b1; absorb = 1'b1; end
          if (hit_i.at_top && ld_data_i == D_LHI) begin lhi_d = 1'b1; absorb = 1'b1; end
          st_d = ST_IDLE;
        end
        ST_WIN:  ;
        default: ;
      endcase
      // a mismatching write abandons the sequence
      if (!absorb && st_q != ST_WIN) st_d = ST_IDLE;
    end
    if (prog_done_i && st_q == ST_WIN) st_d = ST_IDLE;
  end

  assign pass_d  = ld_valid_i && !absorb;
  assign store_d = pass_d && permit && !blk_locked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; prot_q <= 1'b0; id_q <= 1'b0; llo_q <= 1'b0; lhi_q <= 1'b0;
      pass_q <= 1'b0; store_q <= 1'b0; erase_q <= 1'b0;
    end else begin
      st_q <= st_d; prot_q <= prot_d; id_q <= id_d; llo_q <= llo_d; lhi_q <= lhi_d;
      pass_q <= pass_d; store_q <= store_d; erase_q <= erase_d;
    end
  end

  assign ld_pass_o   = pass_q;
  assign ld_store_o  = store_q;
  assign erase_req_o = erase_q;
  assign wr_permit_o = permit;
  assign sw_prot_o   = prot_q;
  assign id_mode_o   = id_q;
  assign lock_lo_o   = llo_q;
  assign lock_hi_o   = lhi_q;
endmodule

// File: rtl/id_read_mux.sv
module id_read_mux #(
  parameter int         AW       = 17,
  parameter logic [7:0] MFR_CODE = 8'h1F,
  parameter logic [7:0] DEV_CODE = 8'hD5
) (
  input  logic [AW-1:0] rd_addr_i,
  input  logic          id_mode_i,
  input  logic          lock_lo_i,
  input  logic          lock_hi_i,
  output logic [7:0]    data_o
);
  localparam logic [AW-1:0] A_MFR  = '0;
  localparam logic [AW-1:0] A_DEV  = AW'(1);
  localparam logic [AW-1:0] A_LLO  = AW'(2);
  localparam logic [AW-1:0] A_LHI  = {{(AW-4){1'b1}}, 4'h2};

  always_comb begin
    data_o = 8'h00;
    if (id_mode_i) begin
      if (rd_addr_i == A_MFR)      data_o = MFR_CODE;
      else if (rd_addr_i == A_DEV) data_o = DEV_CODE;
      else if (rd_addr_i == A_LLO) data_o = {7'h7F, lock_lo_i};
      else if (rd_addr_i == A_LHI) data_o = {7'h7F, lock_hi_i};
    end
  end
endmodule

// File: rtl/cmd_seq_decoder.sv
module cmd_seq_decoder
  import cmd_seq_pkg::*;
#(
  parameter int         AW       = 17,
  parameter int         CMP_W    = 15,
  parameter int         BLK_W    = 13,
  parameter logic [7:0] MFR_CODE = 8'h1F,
  parameter logic [7:0] DEV_CODE = 8'hD5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_valid_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [7:0]    ld_data_i,
  input  logic          prog_done_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          ld_pass_o,
  output logic          ld_store_o,
  output logic          erase_req_o,
  output logic          wr_permit_o,
  output logic          sw_prot_o,
  output logic          id_mode_o,
  output logic          lock_lo_o,
  output logic          lock_hi_o,
  output logic [7:0]    id_rd_data_o
);
  addr_hit_t hit;

  cmd_addr_match #(.AW(AW), .CMP_W(CMP_W), .BLK_W(BLK_W)) u_match (
    .addr_i(ld_addr_i), .hit_o(hit)
  );

  cmd_seq_fsm u_fsm (
    .clk_i, .rst_ni, .ld_valid_i, .ld_data_i, .hit_i(hit), .prog_done_i,
    .ld_pass_o, .ld_store_o, .erase_req_o, .wr_permit_o,
    .sw_prot_o, .id_mode_o, .lock_lo_o, .lock_hi_o
  );

  id_read_mux #(.AW(AW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_idrd (
    .rd_addr_i, .id_mode_i(id_mode_o), .lock_lo_i(lock_lo_o), .lock_hi_i(lock_hi_o),
    .data_o(id_rd_data_o)
  );
endmodule

// File: rtl/cmd_seq_decoder_chk.sv
module cmd_seq_decoder_chk #(
  parameter int AW    = 17,
  parameter int BLK_W = 13
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ld_valid_i,
  input logic [AW-1:0] ld_addr_i,
  input logic          ld_pass_o,
  input logic          ld_store_o,
  input logic          erase_req_o,
  input logic          wr_permit_o,
  input logic          id_mode_o,
  input logic          lock_lo_o,
  input logic          lock_hi_o,
  input logic [7:0]    id_rd_data_o
);
  p_pulse_after_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_pass_o || ld_store_o) |-> $past(ld_valid_i));
  p_store_needs_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_store_o |-> ld_pass_o);
  p_store_needs_permit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_store_o |-> $past(wr_permit_o));
  p_lo_block_guard_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_store_o |-> !($past(lock_lo_o) && $past(ld_addr_i[AW-1:BLK_W]) == '0));
  p_lock_lo_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_lo_o |=> lock_lo_o);
  p_lock_hi_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_hi_o |=> lock_hi_o);
  p_erase_unlocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> !(lock_lo_o || lock_hi_o) && !ld_pass_o);
  p_id_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_mode_o |-> id_rd_data_o == 8'h00);
endmodule

bind cmd_seq_decoder cmd_seq_decoder_chk #(.AW(AW), .BLK_W(BLK_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ld_valid_i(ld_valid_i), .ld_addr_i(ld_addr_i),
  .ld_pass_o(ld_pass_o), .ld_store_o(ld_store_o), .erase_req_o(erase_req_o),
  .wr_permit_o(wr_permit_o), .id_mode_o(id_mode_o), .lock_lo_o(lock_lo_o),
  .lock_hi_o(lock_hi_o), .id_rd_data_o(id_rd_data_o)
);

// File: tb/cmd_seq_decoder_tb_top.sv
module cmd_seq_decoder_tb_top;
  localparam int AW = 17;

  typedef struct {
    logic  p;
    logic  s;
    logic  e;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 1'b0, prog_done = 1'b0;
  logic [AW-1:0] ld_addr = '0, rd_addr = '0;
  logic [7:0] ld_data = '0;
  logic pass, store, erase, permit, prot, idm, llo, lhi;
  logic [7:0] idd;
  logic vld_d = 1'b0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;

  cmd_seq_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ld_valid_i(ld_valid), .ld_addr_i(ld_addr),
    .ld_data_i(ld_data), .prog_done_i(prog_done), .rd_addr_i(rd_addr),
    .ld_pass_o(pass), .ld_store_o(store), .erase_req_o(erase), .wr_permit_o(permit),
    .sw_prot_o(prot), .id_mode_o(idm), .lock_lo_o(llo), .lock_hi_o(lhi),
    .id_rd_data_o(idd)
  );

  always @(posedge clk) vld_d <= ld_valid;

  // monitor: verdict due one cycle after the sampled load
  always @(negedge clk) begin
    if (rst_n) begin
      if (vld_d) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if ({pass, store, erase} !== {e.p, e.s, e.e}) begin
          n_fail++;
          $display("FAIL %s: pass/store/erase=%b%b%b expected %b%b%b",
                   e.tag, pass, store, erase, e.p, e.s, e.e);
        end
      end else if (pass || store || erase) begin
        n_chk++; n_fail++;
        $display("FAIL R11: stray pulse %b%b%b expected 000", pass, store, erase);
      end
    end
  end

  task automatic ld(input logic [AW-1:0] a, input logic [7:0] d,
                    input logic p, input logic s, input logic e, input string tag);
    exp_t x;
    x.p = p; x.s = s; x.e = e; x.tag = tag;
    q.push_back(x);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic cmd(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
    ld(a, d, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic pre6(input string tag);
    cmd(17'h05555, 8'hAA, tag); cmd(17'h02AAA, 8'h55, tag); cmd(17'h05555, 8'h80, tag);
    cmd(17'h05555, 8'hAA, tag); cmd(17'h02AAA, 8'h55, tag);
  endtask

  task automatic pre3(input string tag);
    cmd(17'h05555, 8'hAA, tag); cmd(17'h02AAA, 8'h55, tag);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    rd_addr = a;
    #1;
    chk(idd, exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({3'b0, pass, store, erase, prot, idm}, 8'h00, "R1 pulses/prot/id");
    chk({6'b0, llo, lhi}, 8'h00, "R1 locks");
    chk({7'b0, permit}, 8'h01, "R1 permit");

    ld(17'h04000, 8'h33, 1'b1, 1'b1, 1'b0, "R11 ordinary load");

    // R6 identification entry/exit
    pre3("R6"); cmd(17'h05555, 8'h90, "R6 enter");
    chk({7'b0, idm}, 8'h01, "R6 id mode set");
    rd(17'h00000, 8'h1F, "R6 mfr code");
    rd(17'h00001, 8'hD5, "R6 dev code");
    rd(17'h00002, 8'hFE, "R7 lo unlocked");
    rd(17'h1FFF2, 8'hFE, "R7 hi unlocked");
    rd(17'h00005, 8'h00, "R6 other addr");
    pre3("R6"); cmd(17'h05555, 8'hF0, "R6 exit");
    chk({7'b0, idm}, 8'h00, "R6 id mode clear");
    rd(17'h00000, 8'h00, "R6 read outside mode");

    // R2 upper address bits ignored
    cmd(17'h15555, 8'hAA, "R2"); cmd(17'h0AAAA, 8'h55, "R2"); cmd(17'h1D555, 8'h90, "R2");
    chk({7'b0, idm}, 8'h01, "R2 aliased entry");
    pre3("R6"); cmd(17'h05555, 8'hF0, "R6 exit");

    // R10 broken sequence
    cmd(17'h05555, 8'hAA, "R10");
    ld(17'h02AAA, 8'h12, 1'b1, 1'b1, 1'b0, "R10 break passes");
    ld(17'h02AAA, 8'h55, 1'b1, 1'b1, 1'b0, "R10 back in idle");
    pre6("R10");
    ld(17'h05555, 8'h77, 1'b1, 1'b1, 1'b0, "R10 break in 6-write");
    chk({6'b0, prot, idm}, 8'h00, "R10 no state change");

    // R9 erase with no lock
    pre6("R9"); ld(17'h05555, 8'h10, 1'b0, 1'b0, 1'b1, "R9 erase pulse");

    // R7 lock bottom block
    pre6("R7"); cmd(17'h05555, 8'h40, "R7 arm"); cmd(17'h00000, 8'h00, "R7 lock lo");
    chk({6'b0, llo, lhi}, 8'h02, "R7 lo locked");
    pre3("R7"); cmd(17'h05555, 8'h90, "R7 id enter");
    rd(17'h00002, 8'hFF, "R7 lo status locked");
    rd(17'h1FFF2, 8'hFE, "R7 hi status unlocked");
    pre3("R7"); cmd(17'h05555, 8'hF0, "R7 id exit");

    // R8 locked block rejects storage
    ld(17'h00100, 8'h05, 1'b1, 1'b0, 1'b0, "R8 lo block locked");
    ld(17'h08000, 8'h05, 1'b1, 1'b1, 1'b0, "R8 mid block");
    // R9 erase refused while locked
    pre6("R9"); ld(17'h05555, 8'h10, 1'b0, 1'b0, 1'b0, "R9 erase refused");

    // R7 lock top block
    pre6("R7"); cmd(17'h05555, 8'h40, "R7 arm"); cmd(17'h1FFFF, 8'hFF, "R7 lock hi");
    chk({6'b0, llo, lhi}, 8'h03, "R7 both locked");
    pre3("R7"); cmd(17'h05555, 8'h90, "R7 id enter");
    rd(17'h1FFF2, 8'hFF, "R7 hi status locked");
    pre3("R7"); cmd(17'h05555, 8'hF0, "R7 id exit");
    ld(17'h1F000, 8'h09, 1'b1, 1'b0, 1'b0, "R8 hi block locked");

    // R3 enable protection with window
    pre3("R3"); cmd(17'h05555, 8'hA0, "R3 enable");
    chk({6'b0, prot, permit}, 8'h03, "R3 prot set window open");
    ld(17'h04010, 8'h01, 1'b1, 1'b1, 1'b0, "R3 window store");
    ld(17'h00010, 8'h01, 1'b1, 1'b0, 1'b0, "R8 window locked blk");
    @(negedge clk); prog_done = 1'b1; @(negedge clk); prog_done = 1'b0;
    chk({6'b0, prot, permit}, 8'h02, "R3 window closed");

    // R4 protected load
    ld(17'h04020, 8'h02, 1'b1, 1'b0, 1'b0, "R4 protected no store");
    chk({7'b0, prot}, 8'h01, "R4 prot kept");

    // R3 single unlocked cycle while protected
    pre3("R3"); cmd(17'h05555, 8'hA0, "R3 unlock");
    ld(17'h04030, 8'h03, 1'b1, 1'b1, 1'b0, "R3 unlocked store");
    @(negedge clk); prog_done = 1'b1; @(negedge clk); prog_done = 1'b0;
    chk({7'b0, permit}, 8'h00, "R3 relocked");

    // R5 disable protection
    pre6("R5"); cmd(17'h05555, 8'h20, "R5 disable");
    chk({6'b0, prot, permit}, 8'h01, "R5 prot cleared");
    ld(17'h04040, 8'h04, 1'b1, 1'b1, 1'b0, "R5 store after disable");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule